// File: doc/BRIEF.md
# Lucas-Lehmer Mersenne Primality Tester

This block decides whether the Mersenne number M = 2^q - 1 is prime for an exponent q up to the compile-time limit `MAX_Q` (61 by default). A client places the exponent on `q_in` and pulses `start` while the block is idle. The block loads the working value 4 and performs q-2 passes. Each pass squares the value modulo M and then subtracts two modulo M. When the passes are complete the block raises `done` for one cycle. The final residue and the verdict then sit on `residue` and `is_prime`.

The squaring never forms a full-width product. It uses a shift-add loop that runs one operand bit per cycle, most significant bit first. Because 2^q is congruent to 1 modulo M, doubling modulo M is a one-bit rotation within the low q bits. Each modular addition folds the carry out of bit q-1 back into bit 0, and a result equal to M is mapped to zero. The block therefore needs no divider and no wide multiplier. A pass for exponent q takes roughly q+2 cycles.

Top module: `llt_tester`

## Requirements
- R1: An exponent below 2 or above `MAX_Q` sampled with `start` while idle produces, on the next cycle, `done`=1, `err`=1, `is_prime`=0 and `residue`=0, and `busy` never rises.
- R2: The exponent 2 produces, on the next cycle, `done`=1, `err`=0, `is_prime`=1 and `residue`=0, with zero squaring passes and without `busy` rising.
- R3: An exponent from 3 to `MAX_Q` accepted while idle raises `busy` on the next cycle. `busy` stays high until the cycle in which `done` is 1, and in that cycle `busy` is 0.
- R4: For an exponent from 3 to `MAX_Q`, `residue` equals s(q-2) mod (2^q - 1), where s(0)=4 and s(k+1) = s(k)^2 - 2. The subtraction wraps modulo M. The residue is in canonical form: it is below M, never equal to M, and every bit at position q or above is 0.
- R5: `is_prime` is 1 exactly when the reported residue is 0. For the exponents 2, 3, 5, 7, 13, 17, 19, 31 and 61 it reads 1, and for every other exponent from 3 to `MAX_Q` it reads 0.
- R6: A `start` pulse while `busy` is 1 is ignored. Its exponent has no effect on the run in progress, which reports the result for the exponent first accepted.
- R7: `done` lasts exactly one cycle. `residue`, `is_prime` and `err` change only in a cycle where `done` is 1, and otherwise hold their values until the next result. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a test; honoured only while idle |
| q_in | input | QW ($clog2(MAX_Q+1)) | Exponent q, sampled together with `start` |
| busy | output | 1 | A test is in progress |
| done | output | 1 | One-cycle pulse when a result is ready |
| is_prime | output | 1 | Verdict: 2^q - 1 is prime |
| err | output | 1 | The last request had an exponent out of range |
| residue | output | MAX_Q | Final Lucas-Lehmer value, in canonical form |

## Verification
The bench sweeps every exponent the port can carry, including 0, 1, 2 and the codes above `MAX_Q`. It then adds seeded random exponents. Each residue is compared against a wide-integer model and each verdict against the list of known prime exponents. A broken fold or wrap shows up as a wrong residue for some exponent, and most often also as a wrong verdict. A missing Mq-to-zero mapping leaves a prime exponent with residue M instead of 0, so that exponent is reported as composite. A wrong range check would either start a run on a bad exponent or reject q=2 or q=`MAX_Q`. The bench also fires a second `start` with a different exponent during a run, and a design that restarted or re-latched on that pulse would report the wrong residue.

// File: rtl/llt_pkg.sv
package llt_pkg;
  typedef enum logic [1:0] {
    LLT_IDLE = 2'd0,
    LLT_KICK = 2'd1,
    LLT_WAIT = 2'd2
  } llt_state_e;
endpackage

// File: rtl/llt_qdecode.sv
module llt_qdecode #(
  parameter int MAX_Q = 61,
  localparam int QW = $clog2(MAX_Q + 1),
  localparam int W  = MAX_Q
) (
  input  logic [QW-1:0] q,
  output logic          q_ok,
  output logic          q_two,
  output logic [W-1:0]  mask
);
  function automatic logic [W-1:0] low_ones(logic [QW-1:0] n);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  always_comb begin
    q_ok  = (q >= QW'(2)) && (q <= QW'(MAX_Q));
    q_two = (q == QW'(2));
    mask  = low_ones(q);
  end
endmodule

// File: rtl/llt_modsq.sv
module llt_modsq #(
  parameter int MAX_Q = 61,
  localparam int QW = $clog2(MAX_Q + 1),
  localparam int W  = MAX_Q
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [W-1:0]  x,
  input  logic [QW-1:0] q,
  input  logic [W-1:0]  mask,
  output logic          sq_done,
  output logic [W-1:0]  sq_val
);
  // doubling modulo 2^q-1 is a rotation inside the low q bits
  function automatic logic [W-1:0] rot1(logic [W-1:0] a, logic [QW-1:0] n,
                                        logic [W-1:0] m);
    logic [W-1:0] top;
    top = (a >> (n - QW'(1))) & W'(1);
    return ((a << 1) & m) | top;
  endfunction

  // modular add with end-around carry and Mq -> 0 mapping
  function automatic logic [W-1:0] mod_add(logic [W-1:0] a, logic [W-1:0] b,
                                           logic [QW-1:0] n, logic [W-1:0] m);
    logic [W:0]   s;
    logic [W:0]   hi;
    logic [W-1:0] r;
    s  = {1'b0, a} + {1'b0, b};
    hi = s >> n;
    r  = (s[W-1:0] & m) + hi[W-1:0];
    if (r == m) r = '0;
    return r;
  endfunction

  logic [W-1:0]  x_r, acc, mask_r, acc_nxt;
  logic [QW-1:0] q_r, idx;
  logic          run;
  logic          last_bit;

  assign last_bit = (idx == '0);
  assign acc_nxt  = mod_add(rot1(acc, q_r, mask_r), x_r[idx] ? x_r : '0, q_r, mask_r);
  assign sq_val   = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_r <= '0; acc <= '0; mask_r <= '0; q_r <= '0; idx <= '0;
      run <= 1'b0; sq_done <= 1'b0;
    end else begin
      sq_done <= 1'b0;
      if (go) begin
        x_r    <= x;
        acc    <= '0;
        mask_r <= mask;
        q_r    <= q;
        idx    <= q - QW'(1);
        run    <= 1'b1;
      end else if (run) begin
        acc <= acc_nxt;
        idx <= idx - QW'(1);
        if (last_bit) begin
          run     <= 1'b0;
          sq_done <= 1'b1;
        end
      end
    end
  end

  // R4: accumulator stays canonical throughout the loop
  p_acc_canon_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (((acc & ~mask_r) == '0) && (acc != mask_r)));
  // R3: the controller never restarts a squaring in progress
  p_go_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !run);
endmodule

// File: rtl/llt_ctrl.sv
module llt_ctrl
  import llt_pkg::*;
#(
  parameter int MAX_Q = 61,
  localparam int QW = $clog2(MAX_Q + 1),
  localparam int W  = MAX_Q
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [QW-1:0] q_in,
  input  logic          q_ok,
  input  logic          q_two,
  input  logic [W-1:0]  mask_in,
  output logic          sq_go,
  output logic [W-1:0]  sq_x,
  output logic [QW-1:0] sq_q,
  output logic [W-1:0]  sq_mask,
  input  logic          sq_done,
  input  logic [W-1:0]  sq_val,
  output logic          busy,
  output logic          done,
  output logic          is_prime,
  output logic          err,
  output logic [W-1:0]  residue
);
  // v - 2 modulo m, wrapping for v = 0 and v = 1
  function automatic logic [W-1:0] sub2(logic [W-1:0] v, logic [W-1:0] m);
    if (v >= W'(2)) return v - W'(2);
    return v + m - W'(2);
  endfunction

  llt_state_e    state;
  logic [QW-1:0] q_r, cnt;
  logic [W-1:0]  mask_r, v_r, v_nxt;
  logic          acc_evt, fin_evt;

  assign acc_evt = (state == LLT_IDLE) && start;
  assign fin_evt = (state == LLT_WAIT) && sq_done && (cnt == QW'(1));
  assign v_nxt   = sub2(sq_val, mask_r);
  assign sq_go   = (state == LLT_KICK);
  assign sq_x    = v_r;
  assign sq_q    = q_r;
  assign sq_mask = mask_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LLT_IDLE; q_r <= '0; cnt <= '0; mask_r <= '0; v_r <= '0;
      busy <= 1'b0; done <= 1'b0; is_prime <= 1'b0; err <= 1'b0; residue <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        LLT_IDLE: if (acc_evt) begin
          q_r    <= q_in;
          mask_r <= mask_in;
          if (!q_ok) begin
            done <= 1'b1; err <= 1'b1; is_prime <= 1'b0; residue <= '0;
          end else if (q_two) begin
            done <= 1'b1; err <= 1'b0; is_prime <= 1'b1; residue <= '0;
          end else begin
            v_r   <= W'(4);
            cnt   <= q_in - QW'(2);
            busy  <= 1'b1;
            state <= LLT_KICK;
          end
        end
        LLT_KICK: state <= LLT_WAIT;
        LLT_WAIT: if (sq_done) begin
          if (fin_evt) begin
            done     <= 1'b1;
            err      <= 1'b0;
            is_prime <= (v_nxt == '0);
            residue  <= v_nxt;
            busy     <= 1'b0;
            state    <= LLT_IDLE;
          end else begin
            v_r   <= v_nxt;
            cnt   <= cnt - QW'(1);
            state <= LLT_KICK;
          end
        end
        default: state <= LLT_IDLE;
      endcase
    end
  end

  p_bad_q_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && !q_ok) |=> (done && err && !busy && !is_prime));
  p_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && q_ok && q_two) |=> (done && is_prime && !err && residue == '0));
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_verdict_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (is_prime == (residue == '0)));
  p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(q_r));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(residue) && $stable(is_prime) && $stable(err)));
endmodule

// File: rtl/llt_tester.sv
module llt_tester #(
  parameter int MAX_Q = 61,
  localparam int QW = $clog2(MAX_Q + 1),
  localparam int W  = MAX_Q
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [QW-1:0] q_in,
  output logic          busy,
  output logic          done,
  output logic          is_prime,
  output logic          err,
  output logic [W-1:0]  residue
);
  logic          q_ok, q_two;
  logic [W-1:0]  mask;
  logic          sq_go, sq_done;
  logic [W-1:0]  sq_x, sq_mask, sq_val;
  logic [QW-1:0] sq_q;

  llt_qdecode #(.MAX_Q(MAX_Q)) u_dec (
    .q(q_in), .q_ok(q_ok), .q_two(q_two), .mask(mask)
  );

  llt_ctrl #(.MAX_Q(MAX_Q)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .q_in(q_in),
    .q_ok(q_ok), .q_two(q_two), .mask_in(mask),
    .sq_go(sq_go), .sq_x(sq_x), .sq_q(sq_q), .sq_mask(sq_mask),
    .sq_done(sq_done), .sq_val(sq_val),
    .busy(busy), .done(done), .is_prime(is_prime), .err(err), .residue(residue)
  );

  llt_modsq #(.MAX_Q(MAX_Q)) u_sq (
    .clk(clk), .rst_n(rst_n), .go(sq_go), .x(sq_x), .q(sq_q), .mask(sq_mask),
    .sq_done(sq_done), .sq_val(sq_val)
  );
endmodule

// File: tb/test_llt_tester.sv
module test_llt_tester;
  localparam int MAX_Q = 61;
  localparam int QW = $clog2(MAX_Q + 1);
  localparam int W  = MAX_Q;
  localparam int LIMIT = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [QW-1:0] q_in = '0;
  logic          busy, done, is_prime, err;
  logic [W-1:0]  residue;

  int n_chk = 0;
  int n_bad = 0;
  bit hung  = 1'b0;

  always #2 clk = ~clk;

  llt_tester #(.MAX_Q(MAX_Q)) i_llt_tester (
    .clk(clk), .rst_n(rst_n), .start(start), .q_in(q_in),
    .busy(busy), .done(done), .is_prime(is_prime), .err(err), .residue(residue)
  );

  // wide-integer reference: plain squaring and remainder
  function automatic logic [127:0] ll_model(int q);
    logic [127:0] m, v;
    m = (128'd1 << q) - 128'd1;
    v = 128'd4 % m;
    for (int i = 0; i < q - 2; i++) v = ((v * v) % m + m - 128'd2) % m;
    if (q == 2) v = 128'd0;
    return v;
  endfunction

  function automatic bit known_prime(int q);
    case (q)
      2, 3, 5, 7, 13, 17, 19, 31, 61: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // poke_q >= 0: fire a second start with that exponent mid-run
  task automatic run_q(int q, int poke_q);
    int cyc;
    logic [W-1:0] res_seen;
    bit bad_q;
    bad_q = (q < 2) || (q > MAX_Q);
    @(negedge clk);
    start = 1'b1;
    q_in  = QW'(q);
    @(negedge clk);
    start = 1'b0;
    if (bad_q) begin
      check(done && err && !is_prime && residue == '0 && !busy, "R1 bad exponent",
            {done, err, is_prime, busy}, 4'b1100);
    end else if (q == 2) begin
      check(done && !err && is_prime && residue == '0 && !busy, "R2 exponent two",
            {done, err, is_prime, busy}, 4'b1010);
    end else begin
      check(busy && !done, "R3 busy after start", {busy, done}, 2'b10);
      cyc = 0;
      forever begin
        @(negedge clk);
        cyc++;
        if (poke_q >= 0 && cyc == 5) begin start = 1'b1; q_in = QW'(poke_q); end
        else if (cyc == 6) start = 1'b0;
        if (done) break;
        if (!busy) check(1'b0, "R3 busy dropped early", 0, 1);
        if (cyc > LIMIT) begin
          check(1'b0, "watchdog", cyc, LIMIT);
          hung = 1'b1;
          finish_run();
        end
      end
      start = 1'b0;
      check(!busy, "R3 busy low with done", busy, 0);
      check(residue == W'(ll_model(q)),
            (poke_q >= 0) ? "R6 residue after ignored start" : "R4 residue",
            residue, ll_model(q));
      check(is_prime == known_prime(q), "R5 verdict", is_prime, known_prime(q));
      check(!err, "R5 no error", err, 0);
    end
    res_seen = residue;
    @(negedge clk);
    check(!done && residue == res_seen, "R7 pulse and hold", {done, residue}, {1'b0, res_seen});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !is_prime && residue == '0, "R7 reset state",
          {busy, done, err, is_prime}, 0);
    rst_n = 1'b1;
    // full sweep of the exponent field
    for (int q = 0; q < (1 << QW); q++) run_q(q, -1);
    // restart attempts during a run
    run_q(13, 7);
    run_q(31, 11);
    run_q(MAX_Q, 2);
    // seeded random exponents
    for (int k = 0; k < 10; k++) run_q(int'($urandom_range((1 << QW) - 1, 0)), -1);
    finish_run();
  end
endmodule